// File: doc/BRIEF.md
# MDIO Management Read and Scan Controller

This block is a management-bus master for clause-22 style PHY register reads. A host raises a one-cycle read request, or holds a scan request high, together with a PHY address and a register address. The controller derives the management clock (MDC) from the system clock through an eight-step divider, shifts out an optional preamble and the read header on the data line, releases the line for the turnaround, and captures the sixteen-bit reply.

A single read performs one frame and returns to idle. Scan mode repeats the same read back to back for as long as the scan request stays high. The read-data word is refreshed after every completed frame, so the host always sees the latest value. Three status flags tell the host what is going on: busy, scanning, and a not-valid flag that covers the time before the first result of an operation is available. A soft reset aborts everything and clears the flags.

Top module: `mdio_rd_ctrl`

## Requirements
- R1: The MDC period in system clocks is set by `div_sel` as follows: 0 and 1 give 4, 2 gives 6, 3 gives 8, 4 gives 10, 5 gives 14, 6 gives 20, and 7 gives 28. Each phase lasts half the period. The select is taken when a frame starts from idle.
- R2: With `no_pre` low, a frame opens with 32 driven 1 bits. With `no_pre` high, the frame opens directly with the start bits, so it is 32 MDC periods long instead of 64.
- R3: After the preamble the master drives 14 bits: start `01`, read opcode `10`, the PHY address MSB first, then the register address MSB first. The addresses are latched when the operation starts.
- R4: `mdio_oe` is low for the two turnaround bits and the 16 data bits. The data bits are sampled on MDC rising edges, MSB first, into `rd_data`.
- R5: A single read performs exactly one frame. Busy then drops, and MDC and `mdio_oe` stay low.
- R6: While `scan_req` is high, frames of the same PHY/register pair follow one another with no idle gap. When `scan_req` is low at the end of a frame, that frame is the last one. `scanning` is high for the whole scan operation.
- R7: `busy` is high from the cycle after an accepted request until the last frame ends.
- R8: `not_valid` rises when an operation starts. It falls when the first frame's data is captured and stays low through later scan frames, while `rd_data` updates after each frame.
- R9: A request with PHY address 0 starts no frame.
- R10: A read request that arrives while busy is ignored. No extra frame follows, and the header of the frame in progress keeps its latched addresses.
- R11: `soft_rst` returns the controller to idle within one cycle. Busy, scanning and not-valid are cleared, a scan stops, and MDC is low two cycles later.
- R12: MDC is low whenever no frame runs. `mdio_o` changes only on MDC falling edges and stays stable while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous abort to idle, clears status flags |
| div_sel | input | 3 | MDC divider select |
| no_pre | input | 1 | Suppress the 32-bit preamble |
| rd_req | input | 1 | One-cycle single-read request |
| scan_req | input | 1 | Level-sensitive continuous-read request |
| phy_addr | input | 5 | PHY address (0 is reserved) |
| reg_addr | input | 5 | PHY register address |
| mdio_i | input | 1 | Sampled state of the MDIO line |
| busy | output | 1 | A frame is in progress |
| scanning | output | 1 | A scan operation is active |
| not_valid | output | 1 | The first result of the current operation is not yet captured |
| rd_data | output | 16 | Last captured read value |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | Drive enable for MDIO |

## Verification
The hardest situation to reach is the boundary between two scan frames. There the reply must be captured, the data word must refresh while not-valid stays low, and the next header must begin without a gap, all in the same MDC falling edge. The bench reaches it with a PHY model that counts MDC rising edges and returns a different word in every frame. It then drops the scan request part way through a later frame and checks that exactly that frame completes. A soft reset issued in the middle of a scan frame covers the abort path.

// File: rtl/mdio_rd_pkg.sv
package mdio_rd_pkg;
  localparam int SEL_W  = 3;
  localparam int HALF_W = 4;
  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  // half of the MDC period, in system clocks
  function automatic logic [HALF_W-1:0] half_period(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0, 3'd1: half_period = 4'd2;
      3'd2:       half_period = 4'd3;
      3'd3:       half_period = 4'd4;
      3'd4:       half_period = 4'd5;
      3'd5:       half_period = 4'd7;
      3'd6:       half_period = 4'd10;
      default:    half_period = 4'd14;
    endcase
  endfunction
endpackage

// File: rtl/mdc_clkgen.sv
module mdc_clkgen
  import mdio_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             mdc,
  output logic             rise_tk,
  output logic             fall_tk
);
  logic [HALF_W-1:0] cnt, half_q;
  logic wrap;

  assign wrap    = run && (cnt == half_q - 1'b1);
  assign rise_tk = wrap && !mdc;
  assign fall_tk = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      mdc    <= 1'b0;
      half_q <= half_period('0);
    end else if (!run) begin
      cnt    <= '0;
      mdc    <= 1'b0;
      half_q <= half_period(div_sel);
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R12
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !$past(run)) |-> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              no_pre,
  input  logic              rd_req,
  input  logic              scan_req,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              rise_tk,
  input  logic              fall_tk,
  input  logic              mdio_i,
  output logic              busy,
  output logic              scanning,
  output logic              not_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  import mdio_rd_pkg::*;

  localparam int HDR_W = 4 + 2 * ADDR_W;
  localparam int TX_W  = PRE_LEN + HDR_W;
  localparam int TA_LO = PRE_LEN + HDR_W;
  localparam int DT_LO = TA_LO + 2;
  localparam int TOTAL = DT_LO + DATA_W;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] PRE_IDX = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] TA_IDX  = IDX_W'(TA_LO);
  localparam logic [IDX_W-1:0] DT_IDX  = IDX_W'(DT_LO);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(TOTAL - 1);

  logic [HDR_W-1:0]  hdr_q, hdr_new;
  logic [TX_W-1:0]   txsh;
  logic [DATA_W-1:0] rxsh;
  logic [IDX_W-1:0]  idx;
  logic              pre_off_q;
  logic              want_scan, want_rd, start;

  assign want_scan = scan_req && (phy_addr != '0);
  assign want_rd   = rd_req && (phy_addr != '0);
  assign start     = !busy && (want_scan || want_rd);
  assign hdr_new   = {SOF_BITS, OP_READ, phy_addr, reg_addr};

  function automatic logic [TX_W-1:0] frame_bits(input logic [HDR_W-1:0] h, input logic skip);
    logic [TX_W-1:0] v;
    v = {{PRE_LEN{1'b1}}, h};
    frame_bits = skip ? (v << PRE_LEN) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; scanning <= 1'b0; not_valid <= 1'b0;
      rd_data <= '0; rxsh <= '0; txsh <= '0; hdr_q <= '0;
      idx <= '0; pre_off_q <= 1'b0; mdio_o <= 1'b0; mdio_oe <= 1'b0;
    end else if (soft_rst) begin
      busy <= 1'b0; scanning <= 1'b0; not_valid <= 1'b0;
      idx <= '0; mdio_o <= 1'b0; mdio_oe <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      scanning  <= want_scan;
      not_valid <= 1'b1;
      hdr_q     <= hdr_new;
      pre_off_q <= no_pre;
      idx       <= no_pre ? PRE_IDX : '0;
      txsh      <= frame_bits(hdr_new, no_pre);
      mdio_o    <= frame_bits(hdr_new, no_pre)[TX_W-1];
      mdio_oe   <= 1'b1;
    end else if (busy) begin
      if (rise_tk && idx >= DT_IDX)
        rxsh <= {rxsh[DATA_W-2:0], mdio_i};
      if (fall_tk) begin
        if (idx == LAST) begin
          rd_data   <= rxsh;
          not_valid <= 1'b0;
          if (scanning && scan_req) begin
            idx     <= pre_off_q ? PRE_IDX : '0;
            txsh    <= frame_bits(hdr_q, pre_off_q);
            mdio_o  <= frame_bits(hdr_q, pre_off_q)[TX_W-1];
            mdio_oe <= 1'b1;
          end else begin
            busy     <= 1'b0;
            scanning <= 1'b0;
            mdio_o   <= 1'b0;
            mdio_oe  <= 1'b0;
          end
        end else begin
          idx     <= idx + 1'b1;
          txsh    <= txsh << 1;
          mdio_o  <= txsh[TX_W-2];
          mdio_oe <= (idx + 1'b1) < TA_IDX;
        end
      end
    end
  end

  // R9
  phy_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (hdr_q[2*ADDR_W-1:ADDR_W] != '0));
  // R8
  nv_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> not_valid);
  // R6
  scan_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    scanning |-> busy);
  // R11
  soft_idle_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!busy && !scanning && !not_valid));
endmodule

// File: rtl/mdio_rd_ctrl.sv
module mdio_rd_ctrl #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [2:0]        div_sel,
  input  logic              no_pre,
  input  logic              rd_req,
  input  logic              scan_req,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              mdio_i,
  output logic              busy,
  output logic              scanning,
  output logic              not_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic rise_tk, fall_tk;

  mdc_clkgen u_clk (
    .clk(clk), .rst(rst), .run(busy), .div_sel(div_sel),
    .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
  );

  mdio_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .no_pre(no_pre),
    .rd_req(rd_req), .scan_req(scan_req), .phy_addr(phy_addr), .reg_addr(reg_addr),
    .rise_tk(rise_tk), .fall_tk(fall_tk), .mdio_i(mdio_i),
    .busy(busy), .scanning(scanning), .not_valid(not_valid), .rd_data(rd_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // R12
  mdio_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc) && !$past(soft_rst)) |-> $stable(mdio_o));
  // R5
  oe_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);
endmodule

// File: tb/tb_mdio_rd_ctrl.sv
module tb_mdio_rd_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, soft_rst, no_pre, rd_req, scan_req, mdio_i;
  logic [2:0] div_sel;
  logic [4:0] phy_addr, reg_addr;
  logic busy, scanning, not_valid, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;

  mdio_rd_ctrl dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .div_sel(div_sel), .no_pre(no_pre),
    .rd_req(rd_req), .scan_req(scan_req), .phy_addr(phy_addr), .reg_addr(reg_addr),
    .mdio_i(mdio_i), .busy(busy), .scanning(scanning), .not_valid(not_valid),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  int checks = 0, fails = 0;
  int cyc = 0, rc = 0, flen = 64, last_rise = 0, exp_per = 4, per_bad = 0;
  logic [15:0] base = 16'h0;
  logic rec_o [0:63];
  logic rec_oe [0:63];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] val_for(input int f);
    return base ^ 16'(f * 16'h1111);
  endfunction

  // PHY model: records the master's bits and serves the reply
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(posedge mdc) begin
    int k, k2;
    logic [15:0] v;
    k = rc % flen;
    rec_o[k] = mdio_o;
    rec_oe[k] = mdio_oe;
    if (rc > 0 && (cyc - last_rise) != exp_per) per_bad++;
    last_rise = cyc;
    rc++;
    k2 = rc % flen;
    v = val_for(rc / flen);
    mdio_i = (k2 >= flen - 16) ? v[15 - (k2 - (flen - 16))] : 1'b1;
  end

  function automatic int half_of(input int s);
    case (s)
      0, 1: return 2; 2: return 3; 3: return 4; 4: return 5;
      5: return 7; 6: return 10; default: return 14;
    endcase
  endfunction

  task automatic begin_op(input bit np, input int sel);
    rc = 0; per_bad = 0; no_pre = np; div_sel = 3'(sel);
    flen = np ? 32 : 64;
    exp_per = 2 * half_of(sel);
    mdio_i = 1'b1;
  endtask

  task automatic pulse_rd;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic wait_idle;
    int n = 0;
    while (busy && n < 30000) begin @(negedge clk); n++; end
  endtask

  task automatic check_frame(input bit np, input logic [4:0] pa, input logic [4:0] ra, input string req);
    logic [13:0] hdr;
    int bad_pre = 0, bad_hdr = 0, bad_rel = 0, off;
    hdr = {2'b01, 2'b10, pa, ra};
    off = np ? 0 : 32;
    for (int k = 0; k < flen; k++) begin
      if (k < off) begin
        if (!(rec_o[k] && rec_oe[k])) bad_pre++;
      end else if (k - off < 14) begin
        if (!(rec_oe[k] && rec_o[k] == hdr[13 - (k - off)])) bad_hdr++;
      end else if (rec_oe[k]) bad_rel++;
    end
    chk(bad_pre == 0, "R2", {req, " preamble bits"}, bad_pre, 0);
    chk(bad_hdr == 0, "R3", {req, " header bits"}, bad_hdr, 0);
    chk(bad_rel == 0, "R4", {req, " line released in turnaround/data"}, bad_rel, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !scanning && !not_valid, "R7", "reset flags", {busy, scanning, not_valid}, 0);
    chk(rd_data == 16'h0, "R8", "reset data", rd_data, 0);
    chk(!mdc && !mdio_oe, "R12", "reset mdc/oe", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_single;
    base = 16'hA5C3; phy_addr = 5'd3; reg_addr = 5'd17;
    begin_op(1'b0, 0);
    pulse_rd;
    chk(busy, "R7", "busy after request", busy, 1);
    chk(not_valid, "R8", "not_valid during first frame", not_valid, 1);
    wait_idle;
    check_frame(1'b0, 5'd3, 5'd17, "single");
    chk(rc == 64, "R5", "single read rises", rc, 64);
    chk(rd_data == 16'hA5C3, "R4", "single read data", rd_data, 16'hA5C3);
    chk(!not_valid, "R8", "not_valid after capture", not_valid, 0);
    chk(per_bad == 0, "R1", "period sel0", per_bad, 0);
    repeat (10) @(negedge clk);
    chk(!busy && !mdc && !mdio_oe, "R5", "idle after single read", {busy, mdc, mdio_oe}, 0);
  endtask

  task automatic t_nopre;
    base = 16'h3C96; phy_addr = 5'd31; reg_addr = 5'd1;
    begin_op(1'b1, 2);
    pulse_rd;
    wait_idle;
    check_frame(1'b1, 5'd31, 5'd1, "no-preamble");
    chk(rc == 32, "R2", "no-preamble frame length", rc, 32);
    chk(rd_data == 16'h3C96, "R4", "no-preamble data", rd_data, 16'h3C96);
  endtask

  task automatic t_div;
    for (int s = 0; s < 8; s++) begin
      base = 16'(16'h0101 * (s + 1)); phy_addr = 5'd2; reg_addr = 5'(s);
      begin_op(1'b1, s);
      pulse_rd;
      wait_idle;
      chk(per_bad == 0 && rc == 32, "R1", $sformatf("MDC period sel %0d", s), per_bad, 0);
    end
  endtask

  task automatic t_phy0;
    logic [15:0] keep;
    keep = rd_data;
    phy_addr = 5'd0; reg_addr = 5'd4;
    begin_op(1'b1, 0);
    pulse_rd;
    repeat (40) @(negedge clk);
    chk(!busy && rc == 0, "R9", "PHY 0 read starts nothing", rc, 0);
    chk(rd_data == keep, "R9", "PHY 0 keeps data", rd_data, keep);
    @(negedge clk); scan_req = 1'b1;
    repeat (40) @(negedge clk);
    chk(!busy && !scanning && rc == 0, "R9", "PHY 0 scan starts nothing", {busy, scanning}, 0);
    scan_req = 1'b0;
  endtask

  task automatic t_busy_ignore;
    base = 16'h1234; phy_addr = 5'd6; reg_addr = 5'd5;
    begin_op(1'b0, 0);
    pulse_rd;
    repeat (60) @(negedge clk);
    reg_addr = 5'd9; phy_addr = 5'd7;
    pulse_rd;
    wait_idle;
    repeat (30) @(negedge clk);
    chk(!busy && rc == 64, "R10", "no extra frame from busy request", rc, 64);
    check_frame(1'b0, 5'd6, 5'd5, "R10 latched addresses");
  endtask

  task automatic t_scan;
    base = 16'hBEEF; phy_addr = 5'd9; reg_addr = 5'd2;
    begin_op(1'b1, 0);
    @(negedge clk); scan_req = 1'b1;
    @(negedge clk);
    chk(busy && scanning && not_valid, "R6", "scan started", {busy, scanning, not_valid}, 7);
    while (rc < 2 * 32 + 5) @(negedge clk);
    chk(scanning && busy, "R6", "scanning across frames", {scanning, busy}, 3);
    chk(!not_valid, "R8", "not_valid stays low in scan", not_valid, 0);
    chk(rd_data == val_for(1), "R6", "scan data after frame 1", rd_data, val_for(1));
    scan_req = 1'b0;
    wait_idle;
    chk(rc == 96, "R6", "scan stops after current frame", rc, 96);
    chk(rd_data == val_for(2), "R8", "data from last scan frame", rd_data, val_for(2));
    chk(!scanning && per_bad == 0, "R6", "scan end flags/no gap", {scanning, 1'b0} | per_bad, 0);
  endtask

  task automatic t_soft;
    base = 16'h5555; phy_addr = 5'd4; reg_addr = 5'd3;
    begin_op(1'b1, 3);
    @(negedge clk); scan_req = 1'b1;
    while (rc < 10) @(negedge clk);
    scan_req = 1'b0; soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk(!busy && !scanning && !not_valid, "R11", "soft reset flags", {busy, scanning, not_valid}, 0);
    repeat (2) @(negedge clk);
    chk(!mdc && !mdio_oe, "R11", "soft reset mdc/oe", {mdc, mdio_oe}, 0);
    repeat (20) @(negedge clk);
    chk(!busy, "R11", "stays idle after soft reset", busy, 0);
  endtask

  initial begin
    rst = 1'b1; soft_rst = 1'b0; no_pre = 1'b0; rd_req = 1'b0; scan_req = 1'b0;
    div_sel = 3'd0; phy_addr = 5'd1; reg_addr = 5'd0; mdio_i = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_single;
    t_nopre;
    t_div;
    t_phy0;
    t_busy_ignore;
    t_scan;
    t_soft;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule